// File: doc/BRIEF.md
# Dual-Bank Selectable Clock Divider

This block takes one fast source clock and derives two output banks from it. Each bank has its own 2-bit divide select. Bank A drives one true/complement pair. Bank B drives two pairs that carry the same clock. Each select indexes a fixed ratio table of its own. Odd ratios use both edges of the source, so every ratio except 1 gives a high time of exactly half the output period. A bank set to divide-by-1 acts as a plain buffer of the source.

The source is chosen in front of the dividers. Normally it is the synthesized clock. When the synthesized path is not used, a reference is taken instead: either the crystal clock or the external single-ended clock. A master reset asserts at once and clears both dividers, which forces each true output low and each complement high. Its release passes through a synchronizer on the source clock, so both banks begin their first period on the same rising edge. A new select value takes effect only when the bank finishes its current period, so no shortened pulse appears. All pins are plain control or clock pins. There is no data stream and no handshake.

Top module: `dual_bank_clkdiv`

## Requirements
- R1: Bank A select `a_sel` decodes 0→÷2, 1→÷4, 2→÷5, 3→÷8. Each output period starts with a rising edge on a source rising edge, is high for N source half-cycles and low for N.
- R2: Bank B select `b_sel` decodes 0→÷1, 1→÷2, 2→÷3, 3→÷4, with the same period shape as R1. Both bank B pairs always carry the same level.
- R3: For the odd ratios 3 and 5, the high time is exactly N source half-cycles. This is achieved with falling-edge logic, so the duty cycle is 50%.
- R4: Each complement output `*_n` is always the inverse of its true output `*_p`.
- R5: While `rst` is high, or while its release has not yet passed the synchronizer, every bank not set to ÷1 holds its true outputs low. Assertion of reset acts without waiting for a clock edge.
- R6: A bank set to ÷1 passes the source clock through unchanged, even while reset is held.
- R7: After `rst` falls, the dividers count from the third rising source edge. On that edge both banks start a fresh period high, in phase with each other. No divided output can rise unless the synchronized reset was already low.
- R8: A change of select is adopted only on the rising source edge that ends the bank's current period. The period in progress completes at the old ratio.
- R9: `a_drv` and each bit of `b_drv` follow `a_oe` and `b_oe`. A low flag means the pair is undriven (high impedance).
- R10: The source is `pll_clk` when `use_pll` is 1. When `use_pll` is 0, the source is `xtal_clk` if `use_xtal` is 1, otherwise `ext_clk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pll_clk | input | 1 | Synthesized clock, the normal source |
| xtal_clk | input | 1 | Crystal reference clock |
| ext_clk | input | 1 | External single-ended reference clock |
| use_pll | input | 1 | 1 = take `pll_clk`, 0 = take the selected reference |
| use_xtal | input | 1 | 1 = reference is `xtal_clk`, 0 = `ext_clk` |
| rst | input | 1 | Master reset, active high, asynchronous assert |
| a_sel | input | 2 | Bank A ratio select |
| b_sel | input | 2 | Bank B ratio select |
| a_oe | input | 1 | Bank A output enable, active high |
| b_oe | input | 1 | Bank B output enable, active high |
| a_p | output | A_OUTS (1) | Bank A true outputs |
| a_n | output | A_OUTS (1) | Bank A complement outputs |
| a_drv | output | A_OUTS (1) | Bank A drive flags, 0 = high impedance |
| b_p | output | B_OUTS (2) | Bank B true outputs |
| b_n | output | B_OUTS (2) | Bank B complement outputs |
| b_drv | output | B_OUTS (2) | Bank B drive flags, 0 = high impedance |

## Verification
The bound checker watches bank A on every source edge, and checks three things:
- every gap between successive rises equals one of the table ratios, so no runt period appears across select changes;
- the true output stays low while the synchronized reset is high;
- the output can only rise after the synchronized release, and the first edge after that release drives it high.

Other behaviours only appear in the bench's scenarios, which compare every half-cycle against a behavioural model:
- the exact half-cycle shapes of each ratio on both banks;
- the deferral of select changes;
- the ÷1 buffer running through reset;
- the drive flags;
- the three clock source choices.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/100ps
package clkdiv_pkg;
  localparam int SEL_W   = 2;
  localparam int NUM_SEL = 1 << SEL_W;
  localparam int DIV_W   = 4;

  typedef logic [DIV_W-1:0] div_t;
  typedef div_t [NUM_SEL-1:0] div_tbl_t;

  // entry index equals the select code
  localparam div_tbl_t BANK_A_TBL = {div_t'(8), div_t'(5), div_t'(4), div_t'(2)};
  localparam div_tbl_t BANK_B_TBL = {div_t'(4), div_t'(3), div_t'(2), div_t'(1)};

  function automatic logic tbl_has_odd(div_tbl_t t);
    logic found = 1'b0;
    for (int i = 0; i < NUM_SEL; i++) begin
      if (t[i][0] && (t[i] > div_t'(1))) found = 1'b1;
    end
    return found;
  endfunction

  function automatic logic tbl_contains(div_tbl_t t, int unsigned v);
    logic found = 1'b0;
    for (int i = 0; i < NUM_SEL; i++) begin
      if (int'(t[i]) == int'(v)) found = 1'b1;
    end
    return found;
  endfunction
endpackage

// File: rtl/clk_src_sel.sv
`timescale 1ns/100ps
module clk_src_sel (
  input  logic pll_clk,
  input  logic xtal_clk,
  input  logic ext_clk,
  input  logic use_pll,
  input  logic use_xtal,
  output logic src_clk
);
  logic ref_clk;

  assign ref_clk = use_xtal ? xtal_clk : ext_clk;
  assign src_clk = use_pll ? pll_clk : ref_clk;
endmodule

// File: rtl/rst_release_sync.sv
`timescale 1ns/100ps
module rst_release_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_in,
  output logic rst_out
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or posedge rst_in) begin
    if (rst_in) pipe <= '1;
    else        pipe <= {pipe[STAGES-2:0], 1'b0};
  end

  assign rst_out = pipe[STAGES-1];
endmodule

// File: rtl/bank_div.sv
`timescale 1ns/100ps
module bank_div
  import clkdiv_pkg::*;
#(
  parameter div_tbl_t TBL = BANK_A_TBL
) (
  input  logic             clk,
  input  logic             rst_s,
  input  logic [SEL_W-1:0] sel,
  output logic             div_out
);
  localparam logic HAS_ODD = tbl_has_odd(TBL);

  logic [SEL_W-1:0] cur_sel;
  div_t ratio_cur, ratio_nxt, cnt, cnt_nxt;
  logic fresh, wrap, qp, ext, div1;

  assign ratio_cur = TBL[cur_sel];
  // terminal state: last count of the period, or first edge after release
  assign wrap      = fresh || (cnt == ratio_cur - div_t'(1));
  assign ratio_nxt = wrap ? TBL[sel] : ratio_cur;
  assign cnt_nxt   = wrap ? '0 : cnt + div_t'(1);
  assign div1      = (ratio_cur == div_t'(1));

  always_ff @(posedge clk or posedge rst_s) begin
    if (rst_s) begin
      fresh <= 1'b1;
      cnt   <= '0;
      qp    <= 1'b0;
    end else begin
      fresh <= 1'b0;
      cnt   <= cnt_nxt;
      qp    <= (cnt_nxt < (ratio_nxt >> 1));
    end
  end

  // select is adopted only at the terminal state (fresh is held during reset)
  always_ff @(posedge clk) begin
    if (wrap) cur_sel <= sel;
  end

  generate
    if (HAS_ODD) begin : g_odd
      logic qn, odd;
      assign odd = ratio_cur[0] && !div1;
      always_ff @(negedge clk or posedge rst_s) begin
        if (rst_s) qn <= 1'b0;
        else       qn <= qp;
      end
      assign ext = odd & qn;
    end else begin : g_even
      assign ext = 1'b0;
    end
  endgenerate

  assign div_out = div1 ? clk : (qp | ext);
endmodule

// File: rtl/dual_bank_clkdiv.sv
`timescale 1ns/100ps
module dual_bank_clkdiv
  import clkdiv_pkg::*;
#(
  parameter int A_OUTS      = 1,
  parameter int B_OUTS      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              pll_clk,
  input  logic              xtal_clk,
  input  logic              ext_clk,
  input  logic              use_pll,
  input  logic              use_xtal,
  input  logic              rst,
  input  logic [SEL_W-1:0]  a_sel,
  input  logic [SEL_W-1:0]  b_sel,
  input  logic              a_oe,
  input  logic              b_oe,
  output logic [A_OUTS-1:0] a_p,
  output logic [A_OUTS-1:0] a_n,
  output logic [A_OUTS-1:0] a_drv,
  output logic [B_OUTS-1:0] b_p,
  output logic [B_OUTS-1:0] b_n,
  output logic [B_OUTS-1:0] b_drv
);
  logic src_clk, rst_s, a_clk, b_clk;

  clk_src_sel u_src (
    .pll_clk (pll_clk),
    .xtal_clk(xtal_clk),
    .ext_clk (ext_clk),
    .use_pll (use_pll),
    .use_xtal(use_xtal),
    .src_clk (src_clk)
  );

  rst_release_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (src_clk),
    .rst_in (rst),
    .rst_out(rst_s)
  );

  bank_div #(.TBL(BANK_A_TBL)) u_bank_a (
    .clk    (src_clk),
    .rst_s  (rst_s),
    .sel    (a_sel),
    .div_out(a_clk)
  );

  bank_div #(.TBL(BANK_B_TBL)) u_bank_b (
    .clk    (src_clk),
    .rst_s  (rst_s),
    .sel    (b_sel),
    .div_out(b_clk)
  );

  generate
    for (genvar i = 0; i < A_OUTS; i++) begin : g_a_pair
      assign a_p[i]   = a_clk;
      assign a_n[i]   = ~a_clk;
      assign a_drv[i] = a_oe;
    end
    for (genvar j = 0; j < B_OUTS; j++) begin : g_b_pair
      assign b_p[j]   = b_clk;
      assign b_n[j]   = ~b_clk;
      assign b_drv[j] = b_oe;
    end
  endgenerate
endmodule

// File: rtl/dual_bank_clkdiv_chk.sv
`timescale 1ns/100ps
module dual_bank_clkdiv_chk
  import clkdiv_pkg::*;
#(
  parameter int A_OUTS = 1,
  parameter int GAP_W  = 5
) (
  input logic              src_clk,
  input logic              rst,
  input logic              rst_s,
  input logic [A_OUTS-1:0] a_p
);
  logic [GAP_W-1:0] gap;
  logic a_prev, seen;

  always_ff @(posedge src_clk or posedge rst_s) begin
    if (rst_s) begin
      gap    <= '0;
      seen   <= 1'b0;
      a_prev <= 1'b0;
    end else begin
      a_prev <= a_p[0];
      if (a_p[0] && !a_prev) begin
        gap  <= GAP_W'(1);
        seen <= 1'b1;
      end else if (gap != '1) begin
        gap <= gap + GAP_W'(1);
      end
    end
  end

  // every bank A period is one whole table ratio (no runt across select changes)
  assert_a_period_R1: assert property (@(posedge src_clk) disable iff (rst_s)
    (a_p[0] && !a_prev && seen) |-> tbl_contains(BANK_A_TBL, int'(gap)))
    else $error("bank A period of %0d source cycles is not a table ratio", gap);

  // first edge after synchronized release starts a high period
  assert_first_high_R7: assert property (@(posedge src_clk) disable iff (rst)
    $fell(rst_s) |=> a_p[0])
    else $error("bank A did not start high after release");

  // a divided output never rises while synchronized reset is still high
  assert_rise_after_sync_R7: assert property (@(posedge src_clk) disable iff (rst)
    $rose(a_p[0]) |-> !$past(rst_s))
    else $error("bank A rose before synchronized release");

  always @(negedge src_clk) begin
    if (rst_s) begin
      assert_a_low_R5: assert (a_p == '0)
        else $error("bank A true output high during reset");
    end
  end
endmodule

bind dual_bank_clkdiv dual_bank_clkdiv_chk #(.A_OUTS(A_OUTS)) u_chk (
  .src_clk(src_clk),
  .rst    (rst),
  .rst_s  (rst_s),
  .a_p    (a_p)
);

// File: tb/test_dual_bank_clkdiv.sv
`timescale 1ns/100ps
module test_dual_bank_clkdiv;
  logic pll_clk = 1'b0, xtal_clk = 1'b0, ext_clk = 1'b0;
  logic use_pll, use_xtal, rst, a_oe, b_oe;
  logic [1:0] a_sel, b_sel;
  logic [0:0] a_p, a_n, a_drv;
  logic [1:0] b_p, b_n, b_drv;

  int n_chk = 0, n_fail = 0;
  string req_tag = "R5";
  bit model_on = 1'b0, done = 1'b0;
  int since = 0, an = 0, aph = 0, bn = 0, bph = 0;
  bit run = 1'b0, was_run = 1'b0;

  always #2 pll_clk = ~pll_clk;   // 250 MHz
  always #5 xtal_clk = ~xtal_clk;
  always #7 ext_clk = ~ext_clk;

  dual_bank_clkdiv i_dual_bank_clkdiv (
    .pll_clk(pll_clk), .xtal_clk(xtal_clk), .ext_clk(ext_clk),
    .use_pll(use_pll), .use_xtal(use_xtal), .rst(rst),
    .a_sel(a_sel), .b_sel(b_sel), .a_oe(a_oe), .b_oe(b_oe),
    .a_p(a_p), .a_n(a_n), .a_drv(a_drv),
    .b_p(b_p), .b_n(b_n), .b_drv(b_drv)
  );

  function automatic int ratio_a(logic [1:0] s);
    case (s) 2'd0: return 2; 2'd1: return 4; 2'd2: return 5; default: return 8; endcase
  endfunction
  function automatic int ratio_b(logic [1:0] s);
    return int'(s) + 1;
  endfunction

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic sample(input bit hi);
    bit in_rst;
    logic ea, eb;
    in_rst = rst || (since < 3);
    ea = in_rst ? ((an == 1) ? hi : 1'b0) : (aph < an);
    eb = in_rst ? ((bn == 1) ? hi : 1'b0) : (bph < bn);
    if (model_on) begin
      chk(req_tag, "a_p", a_p[0], ea);
      chk(req_tag, "b_p0", b_p[0], eb);
      chk(req_tag, "b_p1", b_p[1], eb);
      chk("R4", "a_n", a_n[0], ~ea);
      chk("R4", "b_n0", b_n[0], ~eb);
      chk("R4", "b_n1", b_n[1], ~eb);
      chk("R9", "a_drv", a_drv[0], a_oe);
      chk("R9", "b_drv0", b_drv[0], b_oe);
      chk("R9", "b_drv1", b_drv[1], b_oe);
    end
  endtask

  // behavioural reference: half-cycle phase within the current output period
  initial begin
    forever begin
      @(posedge pll_clk);
      if (rst) since = 0; else if (since < 3) since++;
      run = (since >= 3);
      if (!run || !was_run || aph == 2*an - 1) begin an = ratio_a(a_sel); aph = 0; end
      else aph++;
      if (!run || !was_run || bph == 2*bn - 1) begin bn = ratio_b(b_sel); bph = 0; end
      else bph++;
      was_run = run;
      #1 sample(1'b1);
      @(negedge pll_clk);
      if (run && !rst) begin aph++; bph++; end
      #1 sample(1'b0);
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge pll_clk);
    #2.5;
  endtask

  task automatic ref_follow(input bit xt);
    repeat (6) begin
      if (xt) @(posedge xtal_clk); else @(posedge ext_clk);
      #1;
      chk("R10", "b_p high phase", b_p[0], 1'b1);
      chk("R5", "a_p in reset", a_p[0], 1'b0);
      if (xt) @(negedge xtal_clk); else @(negedge ext_clk);
      #1;
      chk("R10", "b_p low phase", b_p[0], 1'b0);
    end
  endtask

  initial begin
    rst = 1'b0; use_pll = 1'b1; use_xtal = 1'b1;
    a_sel = 2'd1; b_sel = 2'd1; a_oe = 1'b1; b_oe = 1'b1;
    #0.5 rst = 1'b1;
    step(3); model_on = 1'b1;
    req_tag = "R5"; step(5);
    req_tag = "R7"; rst = 1'b0; step(30);
    for (int s = 0; s < 4; s++) begin
      req_tag = "R1/R2/R3/R8";
      a_sel = 2'(s); b_sel = 2'(s);
      step(40);
    end
    req_tag = "R8";
    a_sel = 2'd2; b_sel = 2'd2; step(3);
    a_sel = 2'd3; b_sel = 2'd0; step(2);
    a_sel = 2'd0; b_sel = 2'd3; step(1);
    a_sel = 2'd2; step(30);
    req_tag = "R6";
    b_sel = 2'd0; a_sel = 2'd2; step(5);
    rst = 1'b1; step(10);
    b_sel = 2'd2; step(2);
    req_tag = "R7"; rst = 1'b0; step(30);
    req_tag = "R9";
    a_oe = 1'b0; step(8);
    b_oe = 1'b0; a_oe = 1'b1; step(8);
    b_oe = 1'b1; step(4);
    req_tag = "R10";
    rst = 1'b1; b_sel = 2'd0; step(3);
    model_on = 1'b0; use_pll = 1'b0; use_xtal = 1'b1;
    ref_follow(1'b1);
    use_xtal = 1'b0;
    ref_follow(1'b0);
    use_pll = 1'b1; step(3);
    model_on = 1'b1; req_tag = "R6"; step(5);
    req_tag = "R2"; rst = 1'b0; step(20);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule